// File: doc/BRIEF.md
# Segmented Ramp Reference Generator

This block produces the 16-bit code that feeds a reference DAC. The code follows a ramp that is built from a table of up to eight segments. Each segment holds a target level and a slope. An external timing source selects a segment by presenting its index with a trigger strobe. A separate fixed-rate tick then moves the output one step toward that segment's level on each tick. Each step adds or subtracts the slope, and the output is clamped so it never passes the level. Whenever the code changes, a one-cycle write strobe tells the DAC interface to latch the new value.

Software programs the table and the run control through a simple register port. Addresses 0..7 hold the levels and addresses 8..15 hold the slopes. Address 16 is the "run" command. Address 17 is the "stop" command, and reading it returns the present code. Reading address 16 returns the run flag and the active segment.

A four-state machine governs the block:
- S_OFF: stopped, output frozen.
- S_WAIT: running, but no segment has been selected since reset.
- S_SLEW: moving toward the level.
- S_HOLD: the last tick landed on the level.

The transitions are:
- start: S_OFF to S_WAIT, or to S_SLEW if a segment was selected before.
- select: S_WAIT, S_SLEW or S_HOLD to S_SLEW on a trigger.
- land: S_SLEW to S_HOLD on a tick that reaches the level.
- leave: S_HOLD to S_SLEW on a tick that does not land on the level.
- stop: any running state to S_OFF.

Top module: `ramp_ref_gen`

## Requirements
- R1: After reset the code is 0, dac_wr is 0, the active segment is 0, at_level and ramp_on are 0, and every readable address returns 0.
- R2: A write to address i (0..7) sets the level of segment i, and a write to address 8+i sets its slope. Both read back unchanged at the same address.
- R3: A write to address 16 starts the ramp and a write to address 17 stops it, whatever the write data. Reading 16 returns bit 15 = running and bits 2:0 = active segment. Reading 17 returns the code. Writes to addresses 18..31 change nothing, and reads there return 0.
- R4: While stopped, ticks do not change the code and triggers do not change the active segment.
- R5: While running, a trigger makes trig_seg the active segment. Before the first trigger since reset, ticks leave the code unchanged.
- R6: On a tick with the code below the active level, the code rises by the slope, or to the level if the step would reach or pass it.
- R7: On a tick with the code above the active level, the code falls by the slope, or to the level if the step would reach or pass it.
- R8: A slope of 0 moves the code to the level in a single tick.
- R9: dac_wr is high for exactly the cycles in which dac_code holds a value different from the previous cycle.
- R10: A trigger and a tick in the same cycle step the code using the newly selected segment's level and slope.
- R11: A stop write in the same cycle as a tick or trigger wins: no step and no segment change. A later start resumes slewing from the held code toward the active segment's level.
- R12: at_level is high after a tick lands the code on the level, and it goes low after a trigger or a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 5 | register address for read and write |
| reg_wdata | input | 16 | register write data |
| reg_rdata | output | 16 | register read data (combinational on reg_addr) |
| trig_valid | input | 1 | segment trigger strobe |
| trig_seg | input | 3 | segment index carried by the trigger |
| tick | input | 1 | periodic update tick |
| dac_code | output | 16 | reference code to the DAC |
| dac_wr | output | 1 | one-cycle strobe when dac_code changes |
| active_seg | output | 3 | index of the active segment |
| at_level | output | 1 | code has landed on the active level |
| ramp_on | output | 1 | ramp is running |

## Verification
Two pairs of events can fall in the same cycle. A segment trigger can arrive together with an update tick, and a stop write can arrive together with a tick or a trigger. The bench drives these pairs on one clock edge, first the trigger with the tick on alternate segments of a full table sweep, then the stop with both. It compares the code, strobe, segment and level flag against an arithmetic model that applies the new segment's table entry on that edge, or, for the stop, no step and no segment change.

// File: rtl/ramp_ref_pkg.sv
package ramp_ref_pkg;

    // Sequencer states of the ramp engine
    typedef enum logic [1:0] {
        S_OFF  = 2'd0,
        S_WAIT = 2'd1,
        S_SLEW = 2'd2,
        S_HOLD = 2'd3
    } ramp_state_e;

endpackage

// File: rtl/ramp_regfile.sv
module ramp_regfile #(
    parameter int DATA_W = 16,
    parameter int NSEG   = 8,
    localparam int SEG_W  = $clog2(NSEG),
    localparam int ADDR_W = SEG_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [SEG_W-1:0]  sel_seg,
    output logic [DATA_W-1:0] sel_level,
    output logic [DATA_W-1:0] sel_slope,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] level_w [NSEG];
    logic [DATA_W-1:0] slope_w [NSEG];

    // Table region: top address bit clear; bit SEG_W picks slope over level
    logic             wr_tbl;
    logic             wr_is_slope;
    logic [SEG_W-1:0] wr_idx;

    assign wr_tbl      = wr_en && !wr_addr[ADDR_W-1];
    assign wr_is_slope = wr_addr[SEG_W];
    assign wr_idx      = wr_addr[SEG_W-1:0];

    generate
        for (genvar g = 0; g < NSEG; g++) begin : g_entry
            logic [DATA_W-1:0] lvl_r;
            logic [DATA_W-1:0] slp_r;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lvl_r <= '0;
                    slp_r <= '0;
                end else if (wr_tbl && (wr_idx == SEG_W'(g))) begin
                    if (wr_is_slope) begin
                        slp_r <= wr_data;
                    end else begin
                        lvl_r <= wr_data;
                    end
                end
            end

            assign level_w[g] = lvl_r;
            assign slope_w[g] = slp_r;
        end
    endgenerate

    assign sel_level = level_w[sel_seg];
    assign sel_slope = slope_w[sel_seg];

    logic [SEG_W-1:0] rd_idx;
    assign rd_idx = rd_addr[SEG_W-1:0];

    always_comb begin
        if (rd_addr[ADDR_W-1]) begin
            rd_data = '0;
        end else if (rd_addr[SEG_W]) begin
            rd_data = slope_w[rd_idx];
        end else begin
            rd_data = level_w[rd_idx];
        end
    end

endmodule

// File: rtl/ramp_stepper.sv
module ramp_stepper #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] target,
    input  logic [DATA_W-1:0] rate,
    output logic [DATA_W-1:0] nxt,
    output logic              lands
);

    logic [DATA_W-1:0] gap_up;
    logic [DATA_W-1:0] gap_dn;
    logic              rate_zero;

    assign gap_up    = target - cur;
    assign gap_dn    = cur - target;
    assign rate_zero = (rate == '0);

    // Compare the rate against the remaining gap so no sum can wrap
    always_comb begin
        if (cur < target) begin
            if (rate_zero || (rate >= gap_up)) begin
                nxt = target;
            end else begin
                nxt = cur + rate;
            end
        end else if (cur > target) begin
            if (rate_zero || (rate >= gap_dn)) begin
                nxt = target;
            end else begin
                nxt = cur - rate;
            end
        end else begin
            nxt = cur;
        end
    end

    assign lands = (nxt == target);

endmodule

// File: rtl/ramp_seq.sv
module ramp_seq
    import ramp_ref_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NSEG   = 8,
    localparam int SEG_W = $clog2(NSEG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_cmd,
    input  logic              stop_cmd,
    input  logic              trig_valid,
    input  logic [SEG_W-1:0]  trig_seg,
    input  logic              tick,
    input  logic [DATA_W-1:0] level_in,
    input  logic [DATA_W-1:0] nxt_code,
    input  logic              nxt_lands,
    output logic [SEG_W-1:0]  seg_eff,
    output logic [DATA_W-1:0] code_q,
    output logic              dac_wr,
    output logic [SEG_W-1:0]  active_seg_q,
    output logic              at_level,
    output logic              ramp_on
);

    ramp_state_e state_q, state_d;
    logic        seen_q;
    logic        trig_ok;
    logic        running;
    logic        step_ok;

    assign trig_ok = trig_valid && (state_q != S_OFF) && !stop_cmd;
    assign running = ((state_q == S_SLEW) || (state_q == S_HOLD)) && !stop_cmd;
    assign step_ok = tick && (running || trig_ok);
    assign seg_eff = trig_ok ? trig_seg : active_seg_q;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF: begin
                if (run_cmd && !stop_cmd) begin
                    state_d = seen_q ? S_SLEW : S_WAIT;
                end
            end
            S_WAIT, S_SLEW, S_HOLD: begin
                if (stop_cmd) begin
                    state_d = S_OFF;
                end else if (step_ok) begin
                    state_d = nxt_lands ? S_HOLD : S_SLEW;
                end else if (trig_ok) begin
                    state_d = S_SLEW;
                end
            end
            default: state_d = S_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q       <= '0;
            dac_wr       <= 1'b0;
            active_seg_q <= '0;
            seen_q       <= 1'b0;
        end else begin
            dac_wr <= step_ok && (nxt_code != code_q);
            if (step_ok) begin
                code_q <= nxt_code;
            end
            if (trig_ok) begin
                active_seg_q <= trig_seg;
                seen_q       <= 1'b1;
            end
        end
    end

    assign at_level = (state_q == S_HOLD);
    assign ramp_on  = (state_q != S_OFF);

    // R9
    wr_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_wr |-> (code_q != $past(code_q)));

    // R9
    change_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_q != $past(code_q)) |-> dac_wr);

    // R4
    off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_OFF) |=> $stable(code_q));

    // R5
    seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_valid |=> $stable(active_seg_q));

    // R6
    rise_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok && (code_q < level_in)) |=>
            ((code_q <= $past(level_in)) && (code_q > $past(code_q))));

    // R7
    fall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_ok && (code_q > level_in)) |=>
            ((code_q >= $past(level_in)) && (code_q < $past(code_q))));

endmodule

// File: rtl/ramp_ref_gen.sv
module ramp_ref_gen #(
    parameter int DATA_W = 16,
    parameter int NSEG   = 8,
    localparam int SEG_W  = $clog2(NSEG),
    localparam int ADDR_W = SEG_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              trig_valid,
    input  logic [SEG_W-1:0]  trig_seg,
    input  logic              tick,
    output logic [DATA_W-1:0] dac_code,
    output logic              dac_wr,
    output logic [SEG_W-1:0]  active_seg,
    output logic              at_level,
    output logic              ramp_on
);

    localparam logic [ADDR_W-2:0] RUN_OFS  = '0;
    localparam logic [ADDR_W-2:0] STOP_OFS = (ADDR_W-1)'(1);

    logic              ctl_region;
    logic              run_cmd;
    logic              stop_cmd;
    logic [SEG_W-1:0]  seg_eff;
    logic [DATA_W-1:0] sel_level;
    logic [DATA_W-1:0] sel_slope;
    logic [DATA_W-1:0] tbl_rdata;
    logic [DATA_W-1:0] nxt_code;
    logic              nxt_lands;

    assign ctl_region = reg_addr[ADDR_W-1];
    assign run_cmd    = reg_wr && ctl_region && (reg_addr[ADDR_W-2:0] == RUN_OFS);
    assign stop_cmd   = reg_wr && ctl_region && (reg_addr[ADDR_W-2:0] == STOP_OFS);

    ramp_regfile #(.DATA_W(DATA_W), .NSEG(NSEG)) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .wr_addr   (reg_addr),
        .wr_data   (reg_wdata),
        .rd_addr   (reg_addr),
        .sel_seg   (seg_eff),
        .sel_level (sel_level),
        .sel_slope (sel_slope),
        .rd_data   (tbl_rdata)
    );

    ramp_stepper #(.DATA_W(DATA_W)) u_stepper (
        .cur    (dac_code),
        .target (sel_level),
        .rate   (sel_slope),
        .nxt    (nxt_code),
        .lands  (nxt_lands)
    );

    ramp_seq #(.DATA_W(DATA_W), .NSEG(NSEG)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_cmd      (run_cmd),
        .stop_cmd     (stop_cmd),
        .trig_valid   (trig_valid),
        .trig_seg     (trig_seg),
        .tick         (tick),
        .level_in     (sel_level),
        .nxt_code     (nxt_code),
        .nxt_lands    (nxt_lands),
        .seg_eff      (seg_eff),
        .code_q       (dac_code),
        .dac_wr       (dac_wr),
        .active_seg_q (active_seg),
        .at_level     (at_level),
        .ramp_on      (ramp_on)
    );

    // Read mux: table region, status word, present code, else zero
    always_comb begin
        if (!ctl_region) begin
            reg_rdata = tbl_rdata;
        end else if (reg_addr[ADDR_W-2:0] == RUN_OFS) begin
            reg_rdata = {ramp_on, {(DATA_W-1-SEG_W){1'b0}}, active_seg};
        end else if (reg_addr[ADDR_W-2:0] == STOP_OFS) begin
            reg_rdata = dac_code;
        end else begin
            reg_rdata = '0;
        end
    end

endmodule

// File: tb/ramp_ref_gen_bench.sv
module ramp_ref_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        trig_valid = 1'b0;
    logic [2:0]  trig_seg = '0;
    logic        tick = 1'b0;
    logic [15:0] dac_code;
    logic        dac_wr;
    logic [2:0]  active_seg;
    logic        at_level;
    logic        ramp_on;

    int checks = 0;
    int errors = 0;

    // Model state: 0 off, 1 wait, 2 slew, 3 hold
    int          m_st = 0;
    logic        m_seen = 1'b0;
    logic [2:0]  m_seg = '0;
    logic [15:0] m_code = '0;
    logic [15:0] m_lvl [8];
    logic [15:0] m_slp [8];

    always #4 clk = ~clk;

    ramp_ref_gen u_ramp_ref_gen (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .trig_valid(trig_valid),
        .trig_seg(trig_seg), .tick(tick), .dac_code(dac_code), .dac_wr(dac_wr),
        .active_seg(active_seg), .at_level(at_level), .ramp_on(ramp_on)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] step_of(input logic [15:0] c, input logic [15:0] l,
                                            input logic [15:0] s);
        if (c < l) return (s == 0 || s >= l - c) ? l : c + s;
        if (c > l) return (s == 0 || s >= c - l) ? l : c - s;
        return c;
    endfunction

    task automatic model_reset();
        m_st = 0; m_seen = 0; m_seg = 0; m_code = 0;
        for (int i = 0; i < 8; i++) begin m_lvl[i] = 0; m_slp[i] = 0; end
    endtask

    // One clock: drive at negedge, model the edge, sample 2 ns after posedge
    task automatic cyc(input logic wr, input logic [4:0] a, input logic [15:0] d,
                       input logic tv, input logic [2:0] ts, input logic tk,
                       input string tag);
        logic run, stop, trig_ok, step_ok, exp_wr;
        logic [2:0]  se;
        logic [15:0] nxt;
        string ctag;
        reg_wr = wr; reg_addr = a; reg_wdata = d;
        trig_valid = tv; trig_seg = ts; tick = tk;
        run = wr && a == 5'd16;
        stop = wr && a == 5'd17;
        trig_ok = tv && m_st != 0 && !stop;
        se = trig_ok ? ts : m_seg;
        step_ok = tk && ((m_st >= 2 && !stop) || trig_ok);
        nxt = step_of(m_code, m_lvl[se], m_slp[se]);
        ctag = tag;
        if (step_ok) begin
            if (m_slp[se] == 0 && m_code != m_lvl[se]) ctag = "R8";
            else if (m_code < m_lvl[se]) ctag = "R6";
            else if (m_code > m_lvl[se]) ctag = "R7";
        end
        if (m_st == 0) begin
            if (run && !stop) m_st = m_seen ? 2 : 1;
        end else if (stop) m_st = 0;
        else if (step_ok) m_st = (nxt == m_lvl[se]) ? 3 : 2;
        else if (trig_ok) m_st = 2;
        exp_wr = step_ok && nxt != m_code;
        if (step_ok) m_code = nxt;
        if (trig_ok) begin m_seg = ts; m_seen = 1; end
        if (wr && a < 8) m_lvl[a[2:0]] = d;
        else if (wr && a < 16) m_slp[a[2:0]] = d;
        @(posedge clk);
        #2;
        chk(ctag, dac_code, m_code);
        chk("R9", {15'b0, dac_wr}, {15'b0, exp_wr});
        chk("R5", {13'b0, active_seg}, {13'b0, m_seg});
        chk("R12", {15'b0, at_level}, {15'b0, m_st == 3});
        chk("R3", {15'b0, ramp_on}, {15'b0, m_st != 0});
        @(negedge clk);
        reg_wr = 0; trig_valid = 0; tick = 0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [15:0] exp, input string req);
        reg_wr = 0; reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        model_reset();
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic ramp_to_hold(input string tag);
        for (int n = 0; n < 80 && m_st != 3; n++) begin
            cyc(0, 0, 0, 0, 0, 1, tag);
            cyc(0, 0, 0, 0, 0, 0, "R6");
        end
        chk("R12", {15'b0, at_level}, 16'd1);
        cyc(0, 0, 0, 0, 0, 1, "R12");
        cyc(0, 0, 0, 0, 0, 1, "R12");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [15:0] lv [8];
        logic [15:0] sl [8];
        lv = '{16'hF000, 16'h0100, 16'h8000, 16'h7FFF, 16'hFFFF, 16'h0000, 16'h4321, 16'hC000};
        sl = '{16'h0700, 16'h0000, 16'h1000, 16'h0400, 16'hFFFF, 16'h0900, 16'h0555, 16'h0800};
        model_reset();
        @(negedge clk);
        do_reset();

        // R1: reset state and empty register space
        chk("R1", dac_code, 16'h0);
        chk("R1", {15'b0, dac_wr}, 16'h0);
        chk("R1", {13'b0, active_seg}, 16'h0);
        chk("R1", {14'b0, at_level, ramp_on}, 16'h0);
        for (int a = 0; a < 32; a++) rd(5'(a), 16'h0, "R1");

        // R2: program the table and read it back
        for (int s = 0; s < 8; s++) begin
            cyc(1, 5'(s), lv[s], 0, 0, 0, "R2");
            cyc(1, 5'(8 + s), sl[s], 0, 0, 0, "R2");
        end
        // R3: writes above the command addresses change nothing
        for (int a = 18; a < 32; a++) cyc(1, 5'(a), 16'hA5A5, 0, 0, 0, "R3");
        for (int s = 0; s < 8; s++) begin
            rd(5'(s), lv[s], "R2");
            rd(5'(8 + s), sl[s], "R2");
        end
        for (int a = 18; a < 32; a++) rd(5'(a), 16'h0, "R3");
        rd(5'd16, 16'h0000, "R3");

        // R4: stopped block ignores ticks and triggers
        for (int n = 0; n < 4; n++) cyc(0, 0, 0, 1, 3'(n + 2), 1, "R4");

        // R3 + R5: start with nonzero data, wait state ignores ticks
        cyc(1, 5'd16, 16'hFFFF, 0, 0, 0, "R3");
        rd(5'd16, 16'h8000, "R3");
        for (int n = 0; n < 3; n++) cyc(0, 0, 0, 0, 0, 1, "R5");

        // Sweep all segments; odd ones get trigger and tick together (R10)
        for (int s = 0; s < 8; s++) begin
            if (s % 2 == 1) cyc(0, 0, 0, 1, 3'(s), 1, "R10");
            else cyc(0, 0, 0, 1, 3'(s), 0, "R5");
            chk("R12", {15'b0, at_level}, {15'b0, m_st == 3});
            rd(5'd16, {1'b1, 12'b0, 3'(s)}, "R3");
            ramp_to_hold("R6");
            rd(5'd17, m_code, "R3");
        end

        // R11: stop together with tick and trigger, then resume
        cyc(0, 0, 0, 1, 3'd0, 0, "R5");
        cyc(0, 0, 0, 0, 0, 1, "R6");
        cyc(0, 0, 0, 0, 0, 1, "R6");
        cyc(1, 5'd17, 16'h0000, 1, 3'd2, 1, "R11");
        chk("R11", {13'b0, active_seg}, 16'd0);
        for (int n = 0; n < 3; n++) cyc(0, 0, 0, 0, 0, 1, "R4");
        cyc(0, 0, 0, 1, 3'd5, 1, "R4");
        rd(5'd16, 16'h0000, "R4");
        cyc(1, 5'd16, 16'h1234, 0, 0, 0, "R11");
        chk("R11", {15'b0, at_level}, 16'd0);
        ramp_to_hold("R11");
        chk("R11", dac_code, 16'hF000);

        // R2: rewriting the active level moves the held output
        cyc(1, 5'd0, 16'h0040, 0, 0, 0, "R2");
        ramp_to_hold("R7");

        // R1: reset mid-ramp
        cyc(0, 0, 0, 1, 3'd2, 1, "R10");
        do_reset();
        chk("R1", dac_code, 16'h0);
        chk("R1", {14'b0, at_level, ramp_on}, 16'h0);
        for (int a = 0; a < 18; a++) rd(5'(a), 16'h0, "R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule